// File: doc/BRIEF.md
# Per-core power status controller

This block keeps one power record for each core of a cluster. A record holds five fields: a powered flag, a wake-enable bit, a pending-wake flag, a standby-WFI flag and a two-bit wake-reason code. The interrupt controller drives a wake-request set or clear line for each core. A set request always marks the wake as pending. If the core is off and its wake-enable bit is set, the set request also powers the core up. The request's reply line then goes high for one cycle, so the interrupt controller knows it may drop its pending interrupts.

A core can also be powered up by a register-write command, and it stays powered until it receives a power-off command. Any power-up starts a short sequence: the following cycle clears the core's standby-WFI and pending-wake flags and issues a one-cycle power-on pulse, which drives the core's reset and activation. A combinational read port returns the record of one selected core.

Top module: `pwr_status_ctrl`

## Requirements
- R1: A wake-set request without a same-cycle clear sets that core's pending-wake flag at the next clock edge. The one exception is the startup cycle described in R5.
- R2: A wake-set request to a core that is off, has wake-enable set and has no power-off command in the same cycle powers the core at the next edge and records the wake reason 2'b01.
- R3: The wake reply for a core is high for exactly the one cycle after a request that powered that core up under R2. It is low in every other cycle.
- R4: A wake-clear request clears that core's pending-wake flag at the next edge.
- R5: In the cycle after any power-up, the core's pending-wake and standby-WFI flags are cleared and its power-on output is high. This clear takes precedence over a set arriving in that cycle.
- R6: After reset every record reads zero: off, wake-enable clear, no flags, and reason 2'b00 (cold power-on). A power-on command to an off core powers it and records reason 2'b10.
- R7: A wake set and a wake clear for the same core in the same cycle act as a clear only. The pending-wake flag ends clear, the core is not powered up, and the reply stays low.
- R8: The power-on output is a single-cycle pulse. The powered flag stays set until a power-off command. A power-off command in the startup cycle cancels the pulse.
- R9: A wake-set request to a core that is already powered only sets the pending-wake flag. It produces no reply and no power-on pulse.
- R10: With wake-enable clear, a wake-set request to an off core sets the pending-wake flag and leaves the core off.
- R11: The read port returns the record of the core selected by rd_idx_i with this bit layout: [0] powered, [1] wake-enable, [2] pending-wake, [3] standby-WFI, [5:4] wake reason.
- R12: If a wake set and a power-on command reach an off core in the same cycle, the interrupt wake wins when it can power the core (reason 2'b01). A power-off command in the same cycle as either source keeps the core off.
- R13: Requests for one core change no other core's record or outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wake_set_i | input | NUM_CORES | Wake-request assertion, one bit per core |
| wake_clr_i | input | NUM_CORES | Wake-request deassertion, one bit per core |
| pon_cmd_i | input | NUM_CORES | Power-on command from a register write |
| poff_cmd_i | input | NUM_CORES | Power-off command |
| wen_we_i | input | NUM_CORES | Write strobe for the wake-enable bit |
| wen_d_i | input | NUM_CORES | Wake-enable value to write |
| wfi_set_i | input | NUM_CORES | Core has entered standby-WFI |
| wfi_clr_i | input | NUM_CORES | Core has left standby-WFI |
| wake_rsp_o | output | NUM_CORES | One-cycle reply: the wake request powered the core |
| pwr_on_o | output | NUM_CORES | One-cycle power-on pulse to core reset and activation |
| rd_idx_i | input | IDX_W | Core selected on the read port |
| rd_data_o | output | 6 | Status record of the selected core |

## Verification
A powered flag left wrong, or a wake-enable bit that is stale, shows up on the very next request. The reply and the reason code appear one edge after the request, and the power-on pulse appears on the edge after that. A startup clear that is skipped leaves the pending-wake or standby-WFI bit visible on the read port two edges after the request. A wrong precedence between set, clear, power-on and power-off shows as a different record on the read port after a single cycle. The sequence therefore drives each such conflict within one cycle and reads the record back straight away.

// File: rtl/pwr_stat_pkg.sv
package pwr_stat_pkg;

  typedef enum logic [1:0] {
    WAKE_COLD = 2'b00,
    WAKE_IRQ  = 2'b01,
    WAKE_REG  = 2'b10
  } wake_src_e;

  // packed MSB first: [5:4] src, [3] wfi, [2] pend, [1] wen, [0] on
  typedef struct packed {
    wake_src_e src;
    logic      wfi;
    logic      pend;
    logic      wen;
    logic      on;
  } core_stat_t;

  localparam int STAT_W = $bits(core_stat_t);

endpackage

// File: rtl/pwr_core_slice.sv
module pwr_core_slice
  import pwr_stat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wake_set_i,
  input  logic       wake_clr_i,
  input  logic       pon_cmd_i,
  input  logic       poff_cmd_i,
  input  logic       wen_we_i,
  input  logic       wen_d_i,
  input  logic       wfi_set_i,
  input  logic       wfi_clr_i,
  output core_stat_t stat_o,
  output logic       wake_rsp_o,
  output logic       pwr_on_o
);

  logic      on_q, wen_q, pend_q, wfi_q;
  logic      start_q, pon_q, rsp_q;
  wake_src_e src_q;

  logic set_eff, irq_up, reg_up, go_up;

  // clear beats set; power-off beats any power-up; irq wake beats register power-on
  always_comb begin
    set_eff = wake_set_i & ~wake_clr_i;
    irq_up  = set_eff & ~on_q & wen_q & ~poff_cmd_i;
    reg_up  = pon_cmd_i & ~on_q & ~poff_cmd_i & ~irq_up;
    go_up   = irq_up | reg_up;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q    <= 1'b0;
      wen_q   <= 1'b0;
      pend_q  <= 1'b0;
      wfi_q   <= 1'b0;
      src_q   <= WAKE_COLD;
      start_q <= 1'b0;
      pon_q   <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      if (poff_cmd_i)  on_q <= 1'b0;
      else if (go_up)  on_q <= 1'b1;

      if (go_up) src_q <= irq_up ? WAKE_IRQ : WAKE_REG;

      if (wen_we_i) wen_q <= wen_d_i;

      // startup clear precedes core reset
      if (start_q)         pend_q <= 1'b0;
      else if (wake_clr_i) pend_q <= 1'b0;
      else if (wake_set_i) pend_q <= 1'b1;

      if (start_q)        wfi_q <= 1'b0;
      else if (wfi_clr_i) wfi_q <= 1'b0;
      else if (wfi_set_i) wfi_q <= 1'b1;

      start_q <= go_up;
      pon_q   <= start_q & ~poff_cmd_i;
      rsp_q   <= irq_up;
    end
  end

  assign stat_o     = '{src: src_q, wfi: wfi_q, pend: pend_q, wen: wen_q, on: on_q};
  assign wake_rsp_o = rsp_q;
  assign pwr_on_o   = pon_q;

  AST_SET_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_set_i && !wake_clr_i && !start_q |=> pend_q); // R1
  AST_IRQ_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_set_i && !wake_clr_i && !on_q && wen_q && !poff_cmd_i |=> on_q && src_q == WAKE_IRQ); // R2
  AST_RSP_MEANS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_q |-> on_q && src_q == WAKE_IRQ && start_q); // R3
  AST_CLR_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_clr_i |=> !pend_q); // R4
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pon_q |-> !pend_q && !wfi_q && on_q); // R5
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_set_i && wake_clr_i |=> !rsp_q && !pend_q); // R7
  AST_PON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pon_q |=> !pon_q); // R8
  AST_ON_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_q && !poff_cmd_i |=> on_q); // R8
  AST_ON_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_q && !start_q |=> !start_q && !rsp_q); // R9
  AST_OFF_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poff_cmd_i |=> !on_q && !rsp_q); // R12

endmodule

// File: rtl/pwr_stat_rd.sv
module pwr_stat_rd
  import pwr_stat_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 2
) (
  input  core_stat_t [NUM_CORES-1:0] stat_i,
  input  logic [IDX_W-1:0]           idx_i,
  output logic [STAT_W-1:0]          data_o
);

  always_comb begin
    data_o = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (int'(idx_i) == c) data_o = stat_i[c];
    end
  end

endmodule

// File: rtl/pwr_status_ctrl.sv
module pwr_status_ctrl
  import pwr_stat_pkg::*;
#(
  parameter  int NUM_CORES = 4,
  localparam int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CORES-1:0] wake_set_i,
  input  logic [NUM_CORES-1:0] wake_clr_i,
  input  logic [NUM_CORES-1:0] pon_cmd_i,
  input  logic [NUM_CORES-1:0] poff_cmd_i,
  input  logic [NUM_CORES-1:0] wen_we_i,
  input  logic [NUM_CORES-1:0] wen_d_i,
  input  logic [NUM_CORES-1:0] wfi_set_i,
  input  logic [NUM_CORES-1:0] wfi_clr_i,
  output logic [NUM_CORES-1:0] wake_rsp_o,
  output logic [NUM_CORES-1:0] pwr_on_o,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [STAT_W-1:0]    rd_data_o
);

  core_stat_t [NUM_CORES-1:0] stat_all;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    pwr_core_slice u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wake_set_i (wake_set_i[c]),
      .wake_clr_i (wake_clr_i[c]),
      .pon_cmd_i  (pon_cmd_i[c]),
      .poff_cmd_i (poff_cmd_i[c]),
      .wen_we_i   (wen_we_i[c]),
      .wen_d_i    (wen_d_i[c]),
      .wfi_set_i  (wfi_set_i[c]),
      .wfi_clr_i  (wfi_clr_i[c]),
      .stat_o     (stat_all[c]),
      .wake_rsp_o (wake_rsp_o[c]),
      .pwr_on_o   (pwr_on_o[c])
    );
  end

  pwr_stat_rd #(
    .NUM_CORES (NUM_CORES),
    .IDX_W     (IDX_W)
  ) u_rd (
    .stat_i (stat_all),
    .idx_i  (rd_idx_i),
    .data_o (rd_data_o)
  );

  AST_PON_NEEDS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |pwr_on_o |=> ((pwr_on_o & $past(pwr_on_o)) == '0)); // R8

endmodule

// File: tb/pwr_status_ctrl_tb.sv
module pwr_status_ctrl_tb;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0] set_r, clr_r, pon_r, poff_r, wwe_r, wd_r, wfs_r, wfc_r;
  logic [1:0]   idx_r;
  wire  [N-1:0] rsp_w, pon_w;
  wire  [5:0]   rd_w;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  pwr_status_ctrl #(.NUM_CORES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wake_set_i(set_r), .wake_clr_i(clr_r), .pon_cmd_i(pon_r), .poff_cmd_i(poff_r),
    .wen_we_i(wwe_r), .wen_d_i(wd_r), .wfi_set_i(wfs_r), .wfi_clr_i(wfc_r),
    .wake_rsp_o(rsp_w), .pwr_on_o(pon_w), .rd_idx_i(idx_r), .rd_data_o(rd_w)
  );

  // {op[7:0] = set,clr,pon,poff,wen_we,wen_d,wfi_set,wfi_clr ; rsp, pon ; status[5:0]}
  localparam int NV = 19;
  localparam logic [15:0] VEC [NV] = '{
    {8'b1000_0000, 2'b00, 6'b000100}, // R10
    {8'b0100_0000, 2'b00, 6'b000000}, // R4
    {8'b0000_1100, 2'b00, 6'b000010}, // R11
    {8'b1100_0000, 2'b00, 6'b000010}, // R7
    {8'b0000_0010, 2'b00, 6'b001010}, // R11
    {8'b1000_0000, 2'b10, 6'b011111}, // R2 R3
    {8'b0000_0000, 2'b01, 6'b010011}, // R5
    {8'b0000_0000, 2'b00, 6'b010011}, // R8
    {8'b1000_0000, 2'b00, 6'b010111}, // R9
    {8'b0000_0000, 2'b00, 6'b010111}, // R9
    {8'b0001_0000, 2'b00, 6'b010110}, // R8
    {8'b0010_0000, 2'b00, 6'b100111}, // R6
    {8'b0000_0000, 2'b01, 6'b100011}, // R5
    {8'b0001_1000, 2'b00, 6'b100000}, // R8
    {8'b1010_0000, 2'b00, 6'b100101}, // R12
    {8'b0000_0000, 2'b01, 6'b100001}, // R5
    {8'b0001_1100, 2'b00, 6'b100010}, // R8
    {8'b1010_0000, 2'b10, 6'b010111}, // R12
    {8'b0001_0000, 2'b00, 6'b010010}  // R8
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R10";  1: return "R4";   2: return "R11";  3: return "R7";
      4: return "R11";  5: return "R2/R3"; 6: return "R5";  7: return "R8";
      8: return "R9";   9: return "R9";   10: return "R8";  11: return "R6";
      12: return "R5";  13: return "R8";  14: return "R12"; 15: return "R5";
      16: return "R8";  17: return "R12"; default: return "R8";
    endcase
  endfunction

  task automatic idle();
    {set_r, clr_r, pon_r, poff_r, wwe_r, wd_r, wfs_r, wfc_r} = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    idx_r = '0;
    #9 rst_n = 1'b1;
    @(posedge clk); #1;

    // R6: reset state of every record and output
    for (int c = 0; c < N; c++) begin
      idx_r = c[1:0];
      #1 chk("R6 reset", {8'h0, rsp_w, pon_w, 2'b0, rd_w}, 16'h0);
    end
    idx_r = 2'd0;

    // table on core 0
    for (int i = 0; i < NV; i++) begin
      {set_r[0], clr_r[0], pon_r[0], poff_r[0], wwe_r[0], wd_r[0], wfs_r[0], wfc_r[0]} = VEC[i][15:8];
      tick();
      chk(vec_req(i), {8'h0, rsp_w[0], pon_w[0], rd_w}, {8'h0, VEC[i][7:0]});
    end

    // R13: wake with wen clear on core 2 touches no other core
    set_r[2] = 1'b1;
    tick();
    idx_r = 2'd2;
    #1 chk("R13 core2", {10'h0, rd_w}, 16'h0004);
    idx_r = 2'd1;
    #1 chk("R13 core1", {10'h0, rd_w}, 16'h0000);
    chk("R13 outputs", {8'h0, rsp_w, pon_w}, 16'h0);

    // R13: core 3 wake reply and pulse only on bit 3
    wwe_r[3] = 1'b1; wd_r[3] = 1'b1;
    tick();
    set_r[3] = 1'b1;
    tick();
    chk("R13 rsp", {12'h0, rsp_w}, 16'h0008);
    tick();
    chk("R13 pon", {12'h0, pon_w}, 16'h0008);
    idx_r = 2'd3;
    #1 chk("R11 core3", {10'h0, rd_w}, 16'h0013);

    // R12: power-off beats power-on in the same cycle
    pon_r[1] = 1'b1; poff_r[1] = 1'b1;
    tick();
    idx_r = 2'd1;
    #1 chk("R12 off wins", {8'h0, pon_w[1], rsp_w[1], rd_w}, 16'h0000);
    tick();
    chk("R12 no pulse", {12'h0, pon_w}, 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule